// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and keeps exceptions precise. Every instruction carries a small status vector with one bit per fault cause. A fault can be marked in the stage where it is detected, and it then travels with the instruction. Nothing happens when the fault is marked. Only when a faulting instruction arrives at write-back does the block act on it. Because instructions reach write-back strictly in program order, the oldest faulting instruction is always the one that is taken, whatever the order in which the faults were detected.

When a fault is taken, the block blocks the faulting instruction's own writes, flushes every younger instruction, redirects fetch to a fixed trap vector, and saves the faulting PC and the cause. If the faulting instruction sits in the delay slot of a taken branch, the block also saves the branch target. A return-from-exception pulse redirects fetch to the saved PC. When the fault came from a delay slot, a second redirect to the saved branch target follows on the next cycle.

Top module: `excp_tracker`

## Requirements
- R1: After reset all stages are empty. trap_o, redirect_o, mem_we_o and wb_we_o are low. epc_o, epc2_o, in_slot_o and cause_o are zero.
- R2: wb_we_o is high, with wb_pc_o giving that instruction's PC, exactly when a valid instruction with an empty status vector is in write-back.
- R3: mem_we_o is high only for a valid instruction in the memory stage whose vector is empty, counting a data page fault marked in that same cycle. It is also held low in any cycle in which write-back takes a fault.
- R4: When a valid instruction with a nonempty vector is in write-back, trap_o and redirect_o are high in that cycle and redirect_pc_o equals TRAP_VEC. The fetch input of that cycle and all younger instructions are discarded and never write.
- R5: On the cycle after a trap, epc_o holds the faulting PC. cause_o holds the lowest set bit index of its vector, coded as 0 instruction page fault (marked with the fetch), 1 illegal opcode (decode), 2 arithmetic (execute), 3 data page fault (memory).
- R6: If an older instruction in memory and a younger one in decode mark faults in the same cycle, only the older one traps.
- R7: If a younger instruction's fault is marked in an earlier cycle than a fault of the instruction just ahead of it, the older instruction still traps, and only once.
- R8: A faulting instruction fetched right after a taken branch sets in_slot_o to 1 and epc2_o to that branch's target. Otherwise in_slot_o is 0.
- R9: A rfe_i pulse drives redirect_o high with redirect_pc_o = epc_o in that cycle. If in_slot_o is 1, redirect_o is high again on the next cycle with redirect_pc_o = epc2_o. Otherwise it is low on the next cycle.
- R10: A fault marked in fetch reaches write-back and traps exactly five cycles after the instruction was presented to fetch, with no earlier trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | An instruction enters fetch |
| fetch_pc_i | input | PC_W | PC of the entering instruction |
| fetch_ipf_i | input | 1 | Instruction page fault for the entering instruction |
| fetch_taken_i | input | 1 | Entering instruction is a taken branch |
| fetch_target_i | input | PC_W | Target of that branch |
| id_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| ex_arith_i | input | 1 | Arithmetic fault for the instruction in execute |
| mem_dpf_i | input | 1 | Data page fault for the instruction in memory |
| rfe_i | input | 1 | Return-from-exception pulse |
| mem_we_o | output | 1 | Memory write permitted for the memory-stage instruction |
| wb_we_o | output | 1 | Register write permitted for the write-back instruction |
| wb_pc_o | output | PC_W | PC of the write-back instruction |
| trap_o | output | 1 | Fault taken this cycle |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | PC_W | Redirect address |
| epc_o | output | PC_W | Saved faulting PC |
| epc2_o | output | PC_W | Saved branch target for a delay-slot fault |
| in_slot_o | output | 1 | Saved fault was in a delay slot |
| cause_o | output | 2 | Saved cause code |

## Verification
The bench targets faults that are marked out of program order: a load's data page fault marked together with a younger illegal opcode, and a younger fetch fault marked before an older load fault. A design that acted when a fault was marked, instead of at write-back, would trap on the younger instruction and save the wrong PC. A delay-slot arithmetic fault checks both saved PCs and the two-step return. A design that dropped the second PC would resume at the branch's fall-through. A fault in the memory stage is checked to block that stage's own write in the same cycle. Every committed PC is compared against a queue of expected commits, so a flush that let a younger instruction write shows up as an extra commit.

// File: rtl/excp_pkg.sv
package excp_pkg;
    localparam int N_CAUSE = 4;
    localparam int CAUSE_W = $clog2(N_CAUSE);
    localparam int N_STAGE = 5;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_IPF   = 2'd0,
        CZ_ILL   = 2'd1,
        CZ_ARITH = 2'd2,
        CZ_DPF   = 2'd3
    } cause_e;
endpackage

// File: rtl/excp_cause_enc.sv
module excp_cause_enc #(
    parameter int NC = excp_pkg::N_CAUSE,
    parameter int CW = excp_pkg::CAUSE_W
) (
    input  logic [NC-1:0] vec_i,
    output logic [CW-1:0] code_o,
    output logic          any_o
);
    logic [NC:0]   seen;
    logic [NC-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NC; i++) begin : g_chain
        assign seen[i+1] = seen[i] | vec_i[i];
        assign first[i]  = vec_i[i] & ~seen[i];
    end
    assign any_o = seen[NC];

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NC; i++) begin
            if (first[i]) code_o = code_o | CW'(i);
        end
    end
endmodule

// File: rtl/excp_stage_pipe.sv
module excp_stage_pipe #(
    parameter int PC_W = 32,
    parameter int NS   = excp_pkg::N_STAGE,
    parameter int NC   = excp_pkg::N_CAUSE
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 flush_i,
    input  logic                 in_vld_i,
    input  logic [PC_W-1:0]      in_pc_i,
    input  logic [NC-1:0]        in_vec_i,
    input  logic                 in_tk_i,
    input  logic [PC_W-1:0]      in_tg_i,
    input  logic [NS-2:0][NC-1:0] post_i,
    output logic                 mem_vld_o,
    output logic [NC-1:0]        mem_vec_o,
    output logic                 wb_vld_o,
    output logic [PC_W-1:0]      wb_pc_o,
    output logic [NC-1:0]        wb_vec_o,
    output logic                 wb_ds_o,
    output logic [PC_W-1:0]      wb_dtg_o
);
    localparam int WB  = NS - 1;
    localparam int MEM = NS - 2;

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        logic [NC-1:0]   vec;
        logic            tk;
        logic [PC_W-1:0] btg;
        logic            ds;
        logic [PC_W-1:0] dtg;
    } stg_t;

    stg_t [NS-1:0] st_d, st_q;

    always_comb begin
        st_d[0].vld = in_vld_i;
        st_d[0].pc  = in_pc_i;
        st_d[0].vec = in_vec_i;
        st_d[0].tk  = in_tk_i;
        st_d[0].btg = in_tg_i;
        st_d[0].ds  = st_q[0].vld & st_q[0].tk;
        st_d[0].dtg = st_q[0].btg;
        for (int k = 1; k < NS; k++) begin
            st_d[k]     = st_q[k-1];
            st_d[k].vec = st_q[k-1].vec | post_i[k-1];
        end
        if (flush_i) st_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mem_vld_o = st_q[MEM].vld;
    assign mem_vec_o = st_q[MEM].vec;
    assign wb_vld_o  = st_q[WB].vld;
    assign wb_pc_o   = st_q[WB].pc;
    assign wb_vec_o  = st_q[WB].vec;
    assign wb_ds_o   = st_q[WB].ds;
    assign wb_dtg_o  = st_q[WB].dtg;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (!st_q[WB].vld && !st_q[MEM].vld && !st_q[0].vld)); // R4
    AST_VEC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flush_i && st_q[MEM].vld) |=> ((st_q[WB].vec & $past(st_q[MEM].vec)) == $past(st_q[MEM].vec))); // R10
endmodule

// File: rtl/excp_epc_unit.sv
module excp_epc_unit #(
    parameter int              PC_W     = 32,
    parameter int              CW       = excp_pkg::CAUSE_W,
    parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trap_i,
    input  logic            rfe_i,
    input  logic [PC_W-1:0] wb_pc_i,
    input  logic            wb_ds_i,
    input  logic [PC_W-1:0] wb_dtg_i,
    input  logic [CW-1:0]   cause_i,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [PC_W-1:0] epc_o,
    output logic [PC_W-1:0] epc2_o,
    output logic            in_slot_o,
    output logic [CW-1:0]   cause_o
);
    typedef struct packed {
        logic [PC_W-1:0] epc;
        logic [PC_W-1:0] epc2;
        logic            slot;
        logic [CW-1:0]   cause;
        logic            res2;
    } sav_t;

    sav_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.res2 = 1'b0;
        if (trap_i) begin
            s_d.epc   = wb_pc_i;
            s_d.epc2  = wb_ds_i ? wb_dtg_i : '0;
            s_d.slot  = wb_ds_i;
            s_d.cause = cause_i;
        end else if (rfe_i) begin
            s_d.res2 = s_q.slot;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign redirect_o    = trap_i | rfe_i | s_q.res2;
    assign redirect_pc_o = trap_i ? TRAP_VEC : (rfe_i ? s_q.epc : s_q.epc2);
    assign epc_o         = s_q.epc;
    assign epc2_o        = s_q.epc2;
    assign in_slot_o     = s_q.slot;
    assign cause_o       = s_q.cause;

    AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (epc_o == $past(wb_pc_i))); // R5
    AST_SLOT_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rfe_i && !trap_i && in_slot_o) |=> (redirect_o && redirect_pc_o == epc2_o)); // R9
endmodule

// File: rtl/excp_tracker.sv
module excp_tracker #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          fetch_valid_i,
    input  logic [PC_W-1:0]               fetch_pc_i,
    input  logic                          fetch_ipf_i,
    input  logic                          fetch_taken_i,
    input  logic [PC_W-1:0]               fetch_target_i,
    input  logic                          id_illegal_i,
    input  logic                          ex_arith_i,
    input  logic                          mem_dpf_i,
    input  logic                          rfe_i,
    output logic                          mem_we_o,
    output logic                          wb_we_o,
    output logic [PC_W-1:0]               wb_pc_o,
    output logic                          trap_o,
    output logic                          redirect_o,
    output logic [PC_W-1:0]               redirect_pc_o,
    output logic [PC_W-1:0]               epc_o,
    output logic [PC_W-1:0]               epc2_o,
    output logic                          in_slot_o,
    output logic [excp_pkg::CAUSE_W-1:0]  cause_o
);
    import excp_pkg::*;

    logic [N_CAUSE-1:0]              in_vec;
    logic [N_STAGE-2:0][N_CAUSE-1:0] post;
    logic                            mem_vld, wb_vld, wb_ds, wb_any;
    logic [N_CAUSE-1:0]              mem_vec, wb_vec;
    logic [PC_W-1:0]                 wb_pc, wb_dtg;
    logic [CAUSE_W-1:0]              wb_code;
    logic                            flush;

    always_comb begin
        in_vec         = '0;
        in_vec[CZ_IPF] = fetch_ipf_i;
        post           = '0;
        post[1][CZ_ILL]   = id_illegal_i;
        post[2][CZ_ARITH] = ex_arith_i;
        post[3][CZ_DPF]   = mem_dpf_i;
    end

    excp_stage_pipe #(.PC_W(PC_W), .NS(N_STAGE), .NC(N_CAUSE)) pipe_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush),
        .in_vld_i(fetch_valid_i), .in_pc_i(fetch_pc_i), .in_vec_i(in_vec),
        .in_tk_i(fetch_taken_i), .in_tg_i(fetch_target_i), .post_i(post),
        .mem_vld_o(mem_vld), .mem_vec_o(mem_vec),
        .wb_vld_o(wb_vld), .wb_pc_o(wb_pc), .wb_vec_o(wb_vec),
        .wb_ds_o(wb_ds), .wb_dtg_o(wb_dtg)
    );

    excp_cause_enc #(.NC(N_CAUSE), .CW(CAUSE_W)) enc_i (
        .vec_i(wb_vec), .code_o(wb_code), .any_o(wb_any)
    );

    assign trap_o   = wb_vld & wb_any;
    assign flush    = trap_o | rfe_i;
    assign wb_we_o  = wb_vld & ~wb_any;
    assign wb_pc_o  = wb_pc;
    assign mem_we_o = mem_vld & ~(|mem_vec) & ~mem_dpf_i & ~trap_o;

    excp_epc_unit #(.PC_W(PC_W), .CW(CAUSE_W), .TRAP_VEC(TRAP_VEC)) epc_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .trap_i(trap_o), .rfe_i(rfe_i),
        .wb_pc_i(wb_pc), .wb_ds_i(wb_ds), .wb_dtg_i(wb_dtg), .cause_i(wb_code),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .epc2_o(epc2_o), .in_slot_o(in_slot_o), .cause_o(cause_o)
    );

    AST_MEM_WE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> !mem_we_o); // R3
    AST_TRAP_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> (redirect_o && redirect_pc_o == TRAP_VEC)); // R4
    AST_NO_WB_WRITE_ON_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> !wb_we_o); // R2
endmodule

// File: tb/excp_tracker_tb.sv
`timescale 1ns/1ps
module excp_tracker_tb_top;
    localparam logic [31:0] TRAPV = 32'h0000_0080;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        f_vld = 0, f_ipf = 0, f_tk = 0, ill = 0, ar = 0, dpf = 0, rfe = 0;
    logic [31:0] f_pc = 0, f_tg = 0;
    logic        mem_we, wb_we, trap, redir, slot;
    logic [31:0] wb_pc, redir_pc, epc, epc2;
    logic [1:0]  cause;

    excp_tracker #(.PC_W(32), .TRAP_VEC(TRAPV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(f_vld), .fetch_pc_i(f_pc),
        .fetch_ipf_i(f_ipf), .fetch_taken_i(f_tk), .fetch_target_i(f_tg),
        .id_illegal_i(ill), .ex_arith_i(ar), .mem_dpf_i(dpf), .rfe_i(rfe),
        .mem_we_o(mem_we), .wb_we_o(wb_we), .wb_pc_o(wb_pc), .trap_o(trap),
        .redirect_o(redir), .redirect_pc_o(redir_pc), .epc_o(epc), .epc2_o(epc2),
        .in_slot_o(slot), .cause_o(cause)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    int it = 0, trap_cnt = 0, trap_it = -1, mem_cnt = 0;
    bit mon_on = 0;
    logic [31:0] exp_q[$];

    logic [31:0] p_pc[8], p_tg[8];
    bit p_ipf[8], p_tk[8], p_ill[8], p_ar[8], p_dpf[8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: samples just before each rising edge
    always @(negedge clk) begin
        #1.5;
        if (mon_on) begin
            if (trap) begin
                trap_cnt++;
                trap_it = it;
                chk(redir && redir_pc == TRAPV, "R4 trap redirect", redir_pc, TRAPV);
            end
            if (mem_we) mem_cnt++;
            if (wb_we) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected commit", wb_pc, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(wb_pc == e, "R2 commit pc", wb_pc, e);
                end
            end
        end
    end

    task automatic clr_prog();
        for (int i = 0; i < 8; i++) begin
            p_pc[i] = 0; p_tg[i] = 0; p_ipf[i] = 0; p_tk[i] = 0;
            p_ill[i] = 0; p_ar[i] = 0; p_dpf[i] = 0;
        end
        trap_cnt = 0; trap_it = -1; mem_cnt = 0;
    endtask

    task automatic run_prog(input int n);
        mon_on = 1;
        for (int c = 0; c < n + 6; c++) begin
            @(negedge clk);
            it = c;
            f_vld = (c < n);
            f_pc  = (c < n) ? p_pc[c] : 32'h0;
            f_ipf = (c < n) ? p_ipf[c] : 1'b0;
            f_tk  = (c < n) ? p_tk[c] : 1'b0;
            f_tg  = (c < n) ? p_tg[c] : 32'h0;
            ill   = (c >= 2 && c - 2 < n) ? p_ill[c-2] : 1'b0;
            ar    = (c >= 3 && c - 3 < n) ? p_ar[c-3] : 1'b0;
            dpf   = (c >= 4 && c - 4 < n) ? p_dpf[c-4] : 1'b0;
        end
        @(negedge clk);
        f_vld = 0; f_ipf = 0; f_tk = 0; ill = 0; ar = 0; dpf = 0;
        #1.5;
        mon_on = 0;
        chk(exp_q.size() == 0, "R2 commits outstanding", exp_q.size(), 0);
    endtask

    task automatic do_rfe(input bit has_slot, input logic [31:0] e1, input logic [31:0] e2);
        @(negedge clk); rfe = 1; #1.5;
        chk(redir && redir_pc == e1, "R9 rfe redirect", redir_pc, e1);
        @(negedge clk); rfe = 0; #1.5;
        chk(redir == has_slot, "R9 second redirect presence", redir, has_slot);
        if (has_slot) chk(redir_pc == e2, "R9 second redirect pc", redir_pc, e2);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1.5;
        // R1 reset state
        chk(!trap && !redir && !mem_we && !wb_we, "R1 outputs idle", {trap, redir, mem_we, wb_we}, 0);
        chk(epc == 0 && epc2 == 0 && !slot && cause == 0, "R1 saved state zero", epc, 0);

        // S1: clean stream, all commit in order
        clr_prog();
        for (int i = 0; i < 5; i++) begin
            p_pc[i] = 32'h100 + 4 * i;
            exp_q.push_back(32'h100 + 4 * i);
        end
        run_prog(5);
        chk(trap_cnt == 0, "R2 no trap on clean stream", trap_cnt, 0);
        chk(mem_cnt == 5, "R3 memory writes on clean stream", mem_cnt, 5);

        // S2: same-cycle faults, older in memory wins (R6)
        clr_prog();
        p_pc[0] = 32'h200; p_pc[1] = 32'h204; p_pc[2] = 32'h208; p_pc[3] = 32'h20C;
        p_dpf[1] = 1; p_ill[3] = 1;
        exp_q.push_back(32'h200);
        run_prog(4);
        chk(trap_cnt == 1, "R6 single trap", trap_cnt, 1);
        chk(epc == 32'h204, "R6 older fault pc", epc, 32'h204);
        chk(cause == 2'd3, "R5 cause data page fault", cause, 3);
        chk(mem_cnt == 1, "R3 faulting and younger memory writes blocked", mem_cnt, 1);
        do_rfe(0, 32'h204, 32'h0);

        // S3: younger fetch fault marked earlier, older load still wins (R7, R10)
        clr_prog();
        p_pc[0] = 32'h300; p_dpf[0] = 1;
        p_pc[1] = 32'h304; p_ipf[1] = 1;
        run_prog(2);
        chk(trap_cnt == 1, "R7 single trap", trap_cnt, 1);
        chk(epc == 32'h300, "R7 older load pc", epc, 32'h300);
        chk(trap_it == 5, "R10 trap at write-back", trap_it, 5);
        chk(mem_cnt == 0, "R3 no memory writes", mem_cnt, 0);
        chk(!slot, "R8 not a delay slot", slot, 0);

        // S4: arithmetic fault in delay slot of taken branch (R8)
        clr_prog();
        p_pc[0] = 32'h400; p_tk[0] = 1; p_tg[0] = 32'h500;
        p_pc[1] = 32'h404; p_ar[1] = 1;
        p_pc[2] = 32'h500;
        exp_q.push_back(32'h400);
        run_prog(3);
        chk(trap_cnt == 1 && trap_it == 6, "R8 trap cycle", trap_it, 6);
        chk(epc == 32'h404, "R8 slot pc", epc, 32'h404);
        chk(slot == 1'b1, "R8 slot flag", slot, 1);
        chk(epc2 == 32'h500, "R8 branch target saved", epc2, 32'h500);
        chk(cause == 2'd2, "R5 cause arithmetic", cause, 2);
        chk(mem_cnt == 1, "R3 only branch writes memory", mem_cnt, 1);
        do_rfe(1, 32'h404, 32'h500);

        // S5: two causes on one instruction, lowest bit reported (R5, R10)
        clr_prog();
        p_pc[0] = 32'h600; p_ipf[0] = 1; p_ill[0] = 1;
        run_prog(1);
        chk(trap_cnt == 1 && trap_it == 5, "R10 fetch fault latency", trap_it, 5);
        chk(cause == 2'd0, "R5 lowest cause", cause, 0);
        chk(epc == 32'h600 && !slot, "R5 saved pc", epc, 32'h600);
        do_rfe(0, 32'h600, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule